// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache. It sits between a processor load/store port and a next-level memory port that moves whole lines. Each of its lines holds a tag, a valid bit, a dirty bit and a data block. A request that hits completes in the cycle after it is accepted. A request that misses raises `stall` and holds it while the controller moves lines to and from the next level.

A parameter selects one of two write policies. With `WRITE_BACK = 1`, write hits stay in the cache and mark the line dirty. A write miss fetches the line and then merges the write into it. A dirty victim is written out before its replacement is fetched. With `WRITE_BACK = 0`, every write goes to the next level. A write hit also updates the resident line. A write miss bypasses the cache and never fetches a line.

The processor side uses byte addresses and a 4-bit byte enable. A request is accepted on a clock edge where `cpu_req` is high and `stall` is low. The memory side holds a read or write request until `mem_done` pulses for one cycle.

Top module: `dmc_cache`

## Requirements
- R1: The byte address splits into fields as follows. Bits 31..14 are the tag, bits 13..6 select one of 256 lines, bits 5..2 select one of 16 words in the line, and bits 1..0 are the byte. Two addresses with the same line field and different tags evict each other.
- R2: After reset, `stall`, `cpu_ack` and both memory requests are low, and every line is invalid. The first access to any address is a miss.
- R3: A read hit raises `cpu_ack`, with the word on `cpu_rdata`, in the first cycle after acceptance. `stall` stays low and no memory request is made.
- R4: A read miss issues one line read whose `mem_addr` has bits 5..0 at zero. The request is held until `mem_done`. The requested word is then returned with `cpu_ack`.
- R5: Write enable bit i updates only bits 8i+7..8i of the addressed word. All other bytes keep their values.
- R6: In write-back mode a write hit acknowledges in the first cycle after acceptance, marks the line dirty and makes no memory request. The next-level copy stays unchanged.
- R7: In write-back mode a write miss first reads the line from the next level. It then merges the write into the line, and a later read of that word hits with the merged value.
- R8: In write-back mode a miss on a dirty line first writes the old line to the next level, at the old tag's address with every byte of `mem_wmask` set. Only after that write is done does it issue the read, so the modified data reaches the next level.
- R9: In write-through mode a write hit updates the cached word. It also issues one memory write whose `mem_wmask` has at most 4 bits set, covering only the enabled bytes of that word. The line is never marked dirty.
- R10: In write-through mode a write miss issues one memory write and no memory read. The line is not allocated, so a later read of that address misses.
- R11: Tag and valid state change only when a refill completes. A write-around to another tag at the same line field leaves the resident line a hit.
- R12: `stall` stays high from the detection of a miss, or of a write-through write, until `cpu_ack` is delivered, and falls in the cycle after. A new request may be accepted in the same cycle as a hit's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Request completed |
| stall | output | 1 | Controller busy; no request accepted |
| mem_rd_req | output | 1 | Line read request, held until mem_done |
| mem_wr_req | output | 1 | Line write request, held until mem_done |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 512 | Line write data |
| mem_wmask | output | 64 | Byte mask for the line write |
| mem_rdata | input | 512 | Line read data, valid with mem_done |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
Two functions can share a cycle. A write hit commits its merged word into the line array at the same clock edge where the next request is latched. That next request then looks up the same array in the following cycle. The bench provokes this by holding `cpu_req` high across a write hit's acknowledge cycle, with a read of the same word queued behind it. It judges the result by requiring that the read also hits in one cycle and returns the merged value. A second overlap, eviction followed by refill on one line, is judged by the order of operations the memory model logs.

// File: rtl/dmc_pkg.sv
// Shared constants and the controller state type for the direct-mapped cache.
package dmc_pkg;
    localparam int DATA_W     = 32;
    localparam int BYTE_OFF_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } dmc_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
// Tag, valid and dirty state per line.
// Assumes a single index port: lookup and update always address the same line.
module dmc_tag_store #(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] index,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_valid,
    output logic               rd_dirty,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               fill_dirty,
    input  logic               mark_dirty
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_r;
    logic [LINES-1:0] dirty_r;
    logic [TAG_W-1:0] tags [LINES];

    // Valid and dirty flags: cleared by reset, set on refill or write-back hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r <= '0;
            dirty_r <= '0;
        end else if (fill_en) begin
            valid_r[index] <= 1'b1;
            dirty_r[index] <= fill_dirty;
        end else if (mark_dirty) begin
            dirty_r[index] <= 1'b1;
        end
    end

    // Tag array: written only when a refill completes.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tags[index] <= fill_tag;
        end
    end

    assign rd_tag   = tags[index];
    assign rd_valid = valid_r[index];
    assign rd_dirty = dirty_r[index];
endmodule

// File: rtl/dmc_data_store.sv
// Line data array with a whole-line write port and an asynchronous line read.
// Assumes merging of partial writes is done by the caller.
module dmc_data_store #(
    parameter int INDEX_W = 8,
    parameter int LINE_W  = 512
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] index,
    output logic [LINE_W-1:0]  rd_line,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINE_W-1:0] lines [LINES];

    // Line write: replaces the whole line at the current index.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines[index] <= wr_line;
        end
    end

    assign rd_line = lines[index];
endmodule

// File: rtl/dmc_line_merge.sv
// Replaces the enabled bytes of one word inside a line; passes all else through.
// Assumes a word width that is a whole number of bytes.
module dmc_line_merge #(
    parameter int WORD_OFF_W = 4,
    parameter int DATA_W     = 32
) (
    input  logic [(DATA_W << WORD_OFF_W)-1:0] line_in,
    input  logic [WORD_OFF_W-1:0]             word_sel,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [DATA_W/8-1:0]               be,
    input  logic                              en,
    output logic [(DATA_W << WORD_OFF_W)-1:0] line_out
);
    localparam int WORDS = 1 << WORD_OFF_W;
    localparam int BYTES = DATA_W / 8;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            localparam int LSB = w * DATA_W + b * 8;
            assign line_out[LSB +: 8] =
                (en && word_sel == WORD_OFF_W'(w) && be[b]) ? wdata[b*8 +: 8]
                                                            : line_in[LSB +: 8];
        end
    end
endmodule

// File: rtl/dmc_cache.sv
// Direct-mapped data cache controller with a selectable write policy.
// WRITE_BACK=1: write-back with write-allocate; WRITE_BACK=0: write-through
// with write-around. Assumes the memory side holds no more than one request
// and pulses mem_done for exactly one cycle per request.
module dmc_cache
    import dmc_pkg::*;
#(
    parameter bit WRITE_BACK = 1'b1,
    parameter int ADDR_W     = 32,
    parameter int INDEX_W    = 8,
    parameter int WORD_OFF_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cpu_req,
    input  logic                                cpu_we,
    input  logic [ADDR_W-1:0]                   cpu_addr,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    input  logic [DATA_W/8-1:0]                 cpu_be,
    output logic [DATA_W-1:0]                   cpu_rdata,
    output logic                                cpu_ack,
    output logic                                stall,
    output logic                                mem_rd_req,
    output logic                                mem_wr_req,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [(DATA_W << WORD_OFF_W)-1:0]   mem_wdata,
    output logic [(DATA_W/8 << WORD_OFF_W)-1:0] mem_wmask,
    input  logic [(DATA_W << WORD_OFF_W)-1:0]   mem_rdata,
    input  logic                                mem_done
);
    localparam int BYTES      = DATA_W / 8;
    localparam int WORDS      = 1 << WORD_OFF_W;
    localparam int LINE_W     = DATA_W * WORDS;
    localparam int LINE_BYTES = BYTES * WORDS;
    localparam int LINE_OFF_W = WORD_OFF_W + BYTE_OFF_W;
    localparam int TAG_W      = ADDR_W - INDEX_W - LINE_OFF_W;

    dmc_state_t state, state_nx;

    logic [ADDR_W-1:BYTE_OFF_W] addr_q;
    logic                       we_q;
    logic [DATA_W-1:0]          wdata_q;
    logic [BYTES-1:0]           be_q;
    logic                       evict_q;
    logic                       evict_nx;

    logic [TAG_W-1:0]      tag_q;
    logic [INDEX_W-1:0]    index_q;
    logic [WORD_OFF_W-1:0] word_q;
    assign tag_q   = addr_q[ADDR_W-1 -: TAG_W];
    assign index_q = addr_q[LINE_OFF_W +: INDEX_W];
    assign word_q  = addr_q[BYTE_OFF_W +: WORD_OFF_W];

    logic unused_byte_bits;
    assign unused_byte_bits = ^cpu_addr[BYTE_OFF_W-1:0];

    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid, rd_dirty;
    logic [LINE_W-1:0] rd_line, merge_base, merged_line;
    logic              fill_en, mark_dirty, data_wr_en;

    logic hit, hit_done, accept, in_compare;

    assign in_compare = (state == ST_COMPARE);
    assign hit        = rd_valid && (rd_tag == tag_q);
    assign hit_done   = in_compare && hit && (!we_q || WRITE_BACK);
    assign stall      = !((state == ST_IDLE) || hit_done);
    assign accept     = cpu_req && !stall;
    assign cpu_ack    = hit_done || (state == ST_RESPOND);
    assign cpu_rdata  = rd_line[word_q*DATA_W +: DATA_W];

    dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .index(index_q),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .fill_en(fill_en), .fill_tag(tag_q), .fill_dirty(we_q),
        .mark_dirty(mark_dirty)
    );

    assign merge_base = in_compare ? rd_line : mem_rdata;

    dmc_line_merge #(.WORD_OFF_W(WORD_OFF_W), .DATA_W(DATA_W)) u_merge (
        .line_in(merge_base), .word_sel(word_q), .wdata(wdata_q),
        .be(be_q), .en(we_q), .line_out(merged_line)
    );

    dmc_data_store #(.INDEX_W(INDEX_W), .LINE_W(LINE_W)) u_data (
        .clk(clk), .index(index_q), .rd_line(rd_line),
        .wr_en(data_wr_en), .wr_line(merged_line)
    );

    assign fill_en    = (state == ST_REFILL) && mem_done;
    assign mark_dirty = WRITE_BACK && in_compare && hit && we_q;
    assign data_wr_en = (in_compare && hit && we_q) || fill_en;

    // Memory side: victim line for evictions, a single masked word otherwise.
    assign mem_rd_req = (state == ST_REFILL);
    assign mem_wr_req = (state == ST_WRITEBACK);
    assign mem_addr   = (mem_wr_req && evict_q)
                      ? {rd_tag, index_q, {LINE_OFF_W{1'b0}}}
                      : {addr_q[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
    assign mem_wdata  = evict_q ? rd_line : {WORDS{wdata_q}};
    assign mem_wmask  = evict_q ? {LINE_BYTES{1'b1}}
                                : (LINE_BYTES'(be_q) << (word_q * BYTES));

    // Next-state logic: lookup outcome picks eviction, write-out or refill.
    always_comb begin
        state_nx = state;
        evict_nx = evict_q;
        case (state)
            ST_IDLE:
                if (accept) state_nx = ST_COMPARE;
            ST_COMPARE:
                if (hit_done) begin
                    state_nx = accept ? ST_COMPARE : ST_IDLE;
                end else if (!WRITE_BACK && we_q) begin
                    state_nx = ST_WRITEBACK;
                    evict_nx = 1'b0;
                end else if (rd_valid && rd_dirty) begin
                    state_nx = ST_WRITEBACK;
                    evict_nx = 1'b1;
                end else begin
                    state_nx = ST_REFILL;
                end
            ST_WRITEBACK:
                if (mem_done) state_nx = evict_q ? ST_REFILL : ST_RESPOND;
            ST_REFILL:
                if (mem_done) state_nx = ST_RESPOND;
            ST_RESPOND:
                state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            evict_q <= 1'b0;
        end else begin
            state   <= state_nx;
            evict_q <= evict_nx;
        end
    end

    // Request capture: latches the processor request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= cpu_addr[ADDR_W-1:BYTE_OFF_W];
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            be_q    <= cpu_be;
        end
    end
endmodule

// File: rtl/dmc_cache_chk.sv
// Protocol checker for dmc_cache, attached by bind.
// Assumes it sees the controller's latched write flag.
module dmc_cache_chk #(
    parameter bit WRITE_BACK = 1'b1,
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6,
    parameter int LINE_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stall,
    input logic                  cpu_ack,
    input logic                  mem_rd_req,
    input logic                  mem_wr_req,
    input logic                  mem_done,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [LINE_BYTES-1:0] mem_wmask,
    input logic                  we_q
);
    AST_ONE_MEM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R8
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> (mem_addr[LINE_OFF_W-1:0] == '0)); // R4
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_done) |=> mem_rd_req); // R4
    AST_STALL_ON_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> stall); // R12
    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> $past(cpu_ack)); // R12

    if (WRITE_BACK) begin : g_wb
        AST_EVICT_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr_req |-> (&mem_wmask)); // R8
    end else begin : g_wt
        AST_THROUGH_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr_req |-> ($countones(mem_wmask) <= 4)); // R9
        AST_NO_WRITE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
            mem_rd_req |-> !we_q); // R10
    end
endmodule

bind dmc_cache dmc_cache_chk #(
    .WRITE_BACK(WRITE_BACK), .ADDR_W(ADDR_W),
    .LINE_OFF_W(LINE_OFF_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .cpu_ack(cpu_ack),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_done(mem_done),
    .mem_addr(mem_addr), .mem_wmask(mem_wmask), .we_q(we_q)
);

// File: tb/dmc_mem_model.sv
// Next-level memory model: 64 lines reached through address bits 15..14 and 9..6,
// fixed latency, one-cycle done pulse, with counters and an operation log.
module dmc_mem_model #(
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_req,
    input  logic         wr_req,
    input  logic [31:0]  addr,
    input  logic [511:0] wdata,
    input  logic [63:0]  wmask,
    output logic [511:0] rdata,
    output logic         done
);
    logic [31:0] words [1024];
    int          cnt;
    int          rd_cnt;
    int          wr_cnt;
    logic [7:0]  op_log;
    logic [31:0] last_addr;

    initial begin
        for (int i = 0; i < 1024; i++) words[i] = 32'hC0DE0000 ^ (i * 32'h00019E37);
        rd_cnt = 0;
        wr_cnt = 0;
        op_log = '0;
        last_addr = '0;
    end

    // Serves one request after LAT wait cycles, then pulses done.
    always @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            cnt  <= 0;
        end else begin
            done <= 1'b0;
            if ((rd_req || wr_req) && !done) begin
                if (cnt == LAT) begin
                    cnt       <= 0;
                    done      <= 1'b1;
                    last_addr <= addr;
                    op_log    <= {op_log[6:0], wr_req};
                    for (int w = 0; w < 16; w++) begin
                        if (rd_req) rdata[w*32 +: 32] <= words[{addr[15:14], addr[9:6], w[3:0]}];
                        for (int b = 0; b < 4; b++) begin
                            if (wr_req && wmask[w*4+b])
                                words[{addr[15:14], addr[9:6], w[3:0]}][b*8 +: 8] <= wdata[w*32+b*8 +: 8];
                        end
                    end
                    if (rd_req) rd_cnt <= rd_cnt + 1;
                    else        wr_cnt <= wr_cnt + 1;
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end
endmodule

// File: tb/dmc_cache_bench.sv
`timescale 1ns/1ps
module dmc_cache_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        sel = 1'b0;

    logic [31:0]  rdata0, rdata1, maddr0, maddr1;
    logic         ack0, ack1, stall0, stall1, rd0, rd1, wr0, wr1, done0, done1;
    logic [511:0] wd0, wd1, rl0, rl1;
    logic [63:0]  wm0, wm1;

    dmc_cache #(.WRITE_BACK(1'b1)) u_dmc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req && !sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(rdata0), .cpu_ack(ack0), .stall(stall0),
        .mem_rd_req(rd0), .mem_wr_req(wr0), .mem_addr(maddr0), .mem_wdata(wd0),
        .mem_wmask(wm0), .mem_rdata(rl0), .mem_done(done0));
    dmc_mem_model u_mem_wb (.clk(clk), .rst_n(rst_n), .rd_req(rd0), .wr_req(wr0),
        .addr(maddr0), .wdata(wd0), .wmask(wm0), .rdata(rl0), .done(done0));

    dmc_cache #(.WRITE_BACK(1'b0)) u_dmc_cache_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req && sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(rdata1), .cpu_ack(ack1), .stall(stall1),
        .mem_rd_req(rd1), .mem_wr_req(wr1), .mem_addr(maddr1), .mem_wdata(wd1),
        .mem_wmask(wm1), .mem_rdata(rl1), .mem_done(done1));
    dmc_mem_model u_mem_wt (.clk(clk), .rst_n(rst_n), .rd_req(rd1), .wr_req(wr1),
        .addr(maddr1), .wdata(wd1), .wmask(wm1), .rdata(rl1), .done(done1));

    logic [31:0] o_rdata;
    logic        o_ack, o_stall;
    assign o_rdata = sel ? rdata1 : rdata0;
    assign o_ack   = sel ? ack1 : ack0;
    assign o_stall = sel ? stall1 : stall0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] ref_mem [1024];

    function automatic logic [31:0] init_val(int i);
        return 32'hC0DE0000 ^ (i * 32'h00019E37);
    endfunction
    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction
    function automatic logic [31:0] mk_addr(int tag, int idx, int w);
        return (tag << 14) | (idx << 6) | (w << 2);
    endfunction
    function automatic int wid(logic [31:0] a);
        return {a[15:14], a[9:6], a[5:2]};
    endfunction
    function automatic logic [31:0] model_word(logic [31:0] a);
        return sel ? u_mem_wt.words[wid(a)] : u_mem_wb.words[wid(a)];
    endfunction
    function automatic int rd_count();
        return sel ? u_mem_wt.rd_cnt : u_mem_wb.rd_cnt;
    endfunction
    function automatic int wr_count();
        return sel ? u_mem_wt.wr_cnt : u_mem_wb.wr_cnt;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output int cyc,
                      output bit stall_ok);
        bit acc;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        acc = 1'b0;
        while (!acc) begin
            acc = !o_stall;
            @(posedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 1;
        stall_ok = 1'b1;
        while (!o_ack) begin
            if (!o_stall) stall_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        rd = o_rdata;
        if (we) ref_mem[wid(a)] = merge(ref_mem[wid(a)], d, be);
    endtask

    task automatic reset_ref();
        for (int i = 0; i < 1024; i++) ref_mem[i] = init_val(i);
    endtask

    task automatic random_ops(int n);
        logic [31:0] a, d, rd;
        logic [3:0]  be;
        int cyc;
        bit sok, we;
        for (int i = 0; i < n; i++) begin
            a  = mk_addr($urandom % 4, $urandom % 16, $urandom % 16);
            we = ($urandom % 3) == 0;
            d  = $urandom;
            be = 4'($urandom);
            op(we, a, d, be, rd, cyc, sok);
            if (!we) check(rd == ref_mem[wid(a)], "R1 R5 random read", rd, ref_mem[wid(a)]);
            else if (sel) check(model_word(a) == ref_mem[wid(a)], "R9 R10 random through",
                                model_word(a), ref_mem[wid(a)]);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a, b, c, d, e, x;
        int cyc, r0, w0;
        bit sok;
        void'($urandom(32'd20240611));
        reset_ref();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(!stall0 && !ack0 && !rd0 && !wr0, "R2 reset outputs",
              {stall0, ack0, rd0, wr0}, 32'h0);

        // ---------- write-back phase ----------
        sel = 1'b0;
        a = mk_addr(0, 1, 3);
        r0 = rd_count();
        op(0, a, 0, 0, rd, cyc, sok);
        check(cyc > 1 && rd_count() == r0 + 1, "R2 first access misses", cyc, 2);
        check(rd == ref_mem[wid(a)], "R4 miss data", rd, ref_mem[wid(a)]);
        check(u_mem_wb.last_addr == (a & ~32'h3F), "R4 line aligned read", u_mem_wb.last_addr, a & ~32'h3F);
        check(sok, "R12 stall held during miss", sok, 1);
        @(negedge clk);
        check(!o_stall, "R12 stall low after ack", o_stall, 0);

        r0 = rd_count();
        op(0, a, 0, 0, rd, cyc, sok);
        check(cyc == 1 && rd_count() == r0, "R3 read hit one cycle", cyc, 1);
        op(0, mk_addr(0, 1, 5), 0, 0, rd, cyc, sok);
        check(cyc == 1 && rd == ref_mem[wid(mk_addr(0, 1, 5))], "R1 word field same line",
              rd, ref_mem[wid(mk_addr(0, 1, 5))]);

        w0 = wr_count();
        op(1, a, 32'hA1B2C3D4, 4'b0010, rd, cyc, sok);
        check(cyc == 1 && wr_count() == w0, "R6 write hit no memory", cyc, 1);
        check(model_word(a) == init_val(wid(a)), "R6 next level unchanged", model_word(a), init_val(wid(a)));
        op(0, a, 0, 0, rd, cyc, sok);
        check(rd == merge(init_val(wid(a)), 32'hA1B2C3D4, 4'b0010), "R5 byte enable merge",
              rd, merge(init_val(wid(a)), 32'hA1B2C3D4, 4'b0010));

        // R12: write hit and next request accepted in the same cycle
        x = mk_addr(0, 1, 7);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = x; cpu_wdata = 32'h5EED0001; cpu_be = 4'hF;
        @(negedge clk);
        check(o_ack && !o_stall, "R12 hit acknowledge without stall", {o_ack, o_stall}, 2);
        ref_mem[wid(x)] = 32'h5EED0001;
        cpu_we = 1'b0;
        @(negedge clk);
        cpu_req = 1'b0;
        check(o_ack && o_rdata == 32'h5EED0001, "R12 back-to-back read sees write", o_rdata, 32'h5EED0001);

        // R8: conflict with a dirty line
        b = mk_addr(1, 1, 3);
        w0 = wr_count();
        r0 = rd_count();
        op(0, b, 0, 0, rd, cyc, sok);
        check(wr_count() == w0 + 1 && rd_count() == r0 + 1 && u_mem_wb.op_log[1:0] == 2'b10,
              "R8 eviction precedes refill", u_mem_wb.op_log, 2);
        check(model_word(a) == ref_mem[wid(a)], "R8 evicted data preserved", model_word(a), ref_mem[wid(a)]);
        check(rd == ref_mem[wid(b)], "R1 conflicting tag data", rd, ref_mem[wid(b)]);

        // R7: write miss allocates then merges
        c = mk_addr(2, 2, 0);
        r0 = rd_count();
        op(1, c, 32'h77665544, 4'b1100, rd, cyc, sok);
        check(rd_count() == r0 + 1, "R7 write miss fetches line", rd_count(), r0 + 1);
        op(0, c, 0, 0, rd, cyc, sok);
        check(cyc == 1 && rd == ref_mem[wid(c)], "R7 merged after refill", rd, ref_mem[wid(c)]);

        random_ops(400);

        // ---------- write-through phase ----------
        @(negedge clk);
        sel = 1'b1;
        reset_ref();
        d = mk_addr(0, 3, 1);
        op(0, d, 0, 0, rd, cyc, sok);
        check(rd == ref_mem[wid(d)], "R4 through-mode miss data", rd, ref_mem[wid(d)]);
        w0 = wr_count();
        r0 = rd_count();
        op(1, d, 32'h000000EE, 4'b0001, rd, cyc, sok);
        check(cyc > 1 && wr_count() == w0 + 1 && rd_count() == r0, "R9 write hit goes through",
              wr_count(), w0 + 1);
        check(model_word(d) == ref_mem[wid(d)], "R9 next level updated", model_word(d), ref_mem[wid(d)]);
        op(0, d, 0, 0, rd, cyc, sok);
        check(cyc == 1 && rd == ref_mem[wid(d)], "R9 line updated", rd, ref_mem[wid(d)]);

        e = mk_addr(1, 3, 1);
        r0 = rd_count();
        op(1, e, 32'h12345678, 4'b1111, rd, cyc, sok);
        check(rd_count() == r0, "R10 write-around no read", rd_count(), r0);
        check(model_word(e) == ref_mem[wid(e)], "R10 next level written", model_word(e), ref_mem[wid(e)]);
        op(0, d, 0, 0, rd, cyc, sok);
        check(cyc == 1 && rd == ref_mem[wid(d)], "R11 resident line kept", cyc, 1);
        r0 = rd_count();
        op(0, e, 0, 0, rd, cyc, sok);
        check(cyc > 1 && rd_count() == r0 + 1, "R10 not allocated", cyc, 2);
        check(rd == ref_mem[wid(e)], "R10 data after write-around", rd, ref_mem[wid(e)]);

        random_ops(400);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule